// File: doc/BRIEF.md
# Per-Processor Interrupt Level Unit

This unit sits beside one processor and turns three families of interrupt request into a set of fifteen level lines (lines 1 to 15) that feed the processor's own priority logic. The first family is the hard levels that a system-wide master controller has already routed to this processor. The second is a private timer input. The third is soft interrupts that software raises and lowers through a small register bus.

Software sees one 32-bit pending word. The soft interrupts occupy bits 31 to 17, and bit k+16 drives line k. Bit 15 is a sticky flag set by a rising edge on the level-15 broadcast input. Bit 14 mirrors the timer input. Bits 13 to 1 are read-only copies of the routed hard levels. A global master-disable input blocks only the timer and the broadcast flag from reaching the lines. Hard levels and soft interrupts pass through whether it is set or not.

Top module: `cpu_int_level`

## Requirements
- R1: `busRdata` shows the pending word at all times while `busAddr` is 0, and reads as 0 for any other word address.
- R2: A write (`busSel` and `busWr` high) to word address 2 ORs the write data into pending bits 31 to 17. Data bits 16 to 0 of that write have no effect.
- R3: A write to word address 1 clears every pending bit among bits 31 to 17 and bit 15 whose data bit is 1. Data bits 16 and 14 to 0 of that write have no effect.
- R4: Pending bit 14 follows `timerIn`. Line 14 is high when bit 14 is set and `masterOff` is low.
- R5: Pending bit 15 is set by a rising edge of `bcast15`. It is cleared by a falling edge of `bcast15` or by a clear write with data bit 15 set. Line 15 is high when bit 15 is set and `masterOff` is low.
- R6: Pending bits 13 to 1 copy `hardLvl[13:1]`, and pending bits 16 and 0 always read 0. Each line k from 1 to 15 is high when `hardLvl[k]` is high. `hardLvl[0]` has no effect, and `levelOut[0]` is always 0.
- R7: A soft bit, once set, stays set until a clear write selects it. Line k from 1 to 15 is high while pending bit k+16 is set.
- R8: `masterOff` blocks neither the hard levels nor the soft interrupts from reaching the lines.
- R9: After reset, the pending word and all level lines are 0.
- R10: A write or input change sampled at clock edge N shows in the pending readback after edge N. It shows on `levelOut` after edge N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hardLvl | input | 16 | Hard levels routed from the master controller; bit 0 unused |
| bcast15 | input | 1 | Level-15 broadcast flag |
| masterOff | input | 1 | Global master disable |
| timerIn | input | 1 | Private timer level |
| busSel | input | 1 | Register access valid |
| busWr | input | 1 | Access is a write |
| busAddr | input | 2 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| levelOut | output | 16 | Processor level lines; bit 0 is never driven high |

## Verification
On every cycle, the assertions check three things. Soft bits hold unless a clear strobe selects them. A set or clear strobe leaves the selected bits in the intended state. The timer reaches line 14 or is blocked according to `masterOff`. The bench sweeps every bit position through the set and clear registers and every hard level through the lines, and checks them against an arithmetic model. Only those scenarios can show some behaviours: the masking of unused data bits, the zero readback of the other offsets, the edge-driven broadcast flag, and the two-stage latency from input to line.

// File: rtl/cpu_lvl_pkg.sv
package cpu_lvl_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_LVL    = 16;
  localparam int ADDR_W     = 2;
  localparam int SOFT_SHIFT = 16;
  localparam int SOFT_LSB   = SOFT_SHIFT + 1;
  localparam int TIMER_BIT  = 14;
  localparam int BCAST_BIT  = 15;

  localparam logic [DATA_W-1:0] SOFT_MASK = ~((32'd1 << SOFT_LSB) - 32'd1);
  localparam logic [DATA_W-1:0] CLR_MASK  = SOFT_MASK | (32'd1 << BCAST_BIT);
  localparam logic [DATA_W-1:0] DISP_MASK = ((32'd1 << TIMER_BIT) - 32'd1) & ~32'd1;

  localparam logic [ADDR_W-1:0] OFS_PEND = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_SET  = 2'd2;

  typedef struct packed {
    logic              setSoft;
    logic              clrPend;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/cpu_lvl_ctrl.sv
module cpu_lvl_ctrl
  import cpu_lvl_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] pendWord,
  output strobe_t           strb,
  output logic [DATA_W-1:0] busRdata
);
  logic wrHit;
  assign wrHit = busSel && busWr;

  always_comb begin
    strb.setSoft = wrHit && (busAddr == OFS_SET);
    strb.clrPend = wrHit && (busAddr == OFS_CLR);
    if (strb.setSoft) strb.data = busWdata & SOFT_MASK;
    else if (strb.clrPend) strb.data = busWdata & CLR_MASK;
    else strb.data = '0;
  end

  assign busRdata = (busAddr == OFS_PEND) ? pendWord : '0;
endmodule

// File: rtl/cpu_lvl_datapath.sv
module cpu_lvl_datapath
  import cpu_lvl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strb,
  input  logic [NUM_LVL-1:0] hardLvl,
  input  logic               bcast15,
  input  logic               masterOff,
  input  logic               timerIn,
  output logic [DATA_W-1:0]  pendWord,
  output logic [NUM_LVL-1:0] levelOut
);
  logic [DATA_W-1:0]  softQ, softNext;
  logic [NUM_LVL-1:0] hardQ, levelNext;
  logic               bcastQ, bcastPrev, timerQ, bcastNext;

  always_comb begin
    softNext = softQ;
    if (strb.setSoft) softNext = softNext | strb.data;
    if (strb.clrPend) softNext = softNext & ~strb.data;
    softNext = softNext & SOFT_MASK;
    bcastNext = bcastQ;
    if (bcast15 && !bcastPrev) bcastNext = 1'b1;
    else if (!bcast15 && bcastPrev) bcastNext = 1'b0;
    else if (strb.clrPend && strb.data[BCAST_BIT]) bcastNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      softQ     <= '0;
      hardQ     <= '0;
      bcastQ    <= 1'b0;
      bcastPrev <= 1'b0;
      timerQ    <= 1'b0;
    end else begin
      softQ     <= softNext;
      hardQ     <= {hardLvl[NUM_LVL-1:1], 1'b0};
      bcastQ    <= bcastNext;
      bcastPrev <= bcast15;
      timerQ    <= timerIn;
    end
  end

  always_comb begin
    pendWord = softQ | ({{(DATA_W-NUM_LVL){1'b0}}, hardQ} & DISP_MASK);
    pendWord[BCAST_BIT] = bcastQ;
    pendWord[TIMER_BIT] = timerQ;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LVL; g++) begin : g_line
      if (g == 0) begin : g_zero
        assign levelNext[g] = 1'b0;
      end else if (g >= TIMER_BIT) begin : g_gated
        assign levelNext[g] = hardQ[g] | softQ[g+SOFT_SHIFT] | (pendWord[g] & ~masterOff);
      end else begin : g_plain
        assign levelNext[g] = hardQ[g] | softQ[g+SOFT_SHIFT];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) levelOut <= '0;
    else        levelOut <= levelNext;
  end

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setSoft |=> ((pendWord & $past(strb.data)) == $past(strb.data)));

  a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrPend |=> ((pendWord & $past(strb.data) & SOFT_MASK) == '0));

  a_r7_soft_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clrPend |=> ((pendWord & $past(pendWord) & SOFT_MASK) == ($past(pendWord) & SOFT_MASK)));

  a_r4_timer_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (timerQ && !masterOff) |=> levelOut[TIMER_BIT]);

  a_r4_timer_block: assert property (@(posedge clk) disable iff (!rst_n)
    (masterOff && !hardQ[TIMER_BIT] && !softQ[TIMER_BIT+SOFT_SHIFT]) |=> !levelOut[TIMER_BIT]);
endmodule

// File: rtl/cpu_int_level.sv
module cpu_int_level
  import cpu_lvl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] hardLvl,
  input  logic               bcast15,
  input  logic               masterOff,
  input  logic               timerIn,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_LVL-1:0] levelOut
);
  strobe_t           strb;
  logic [DATA_W-1:0] pendWord;

  cpu_lvl_ctrl i_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .pendWord(pendWord), .strb(strb), .busRdata(busRdata)
  );

  cpu_lvl_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .hardLvl(hardLvl), .bcast15(bcast15),
    .masterOff(masterOff), .timerIn(timerIn), .pendWord(pendWord), .levelOut(levelOut)
  );
endmodule

// File: tb/test_cpu_int_level.sv
`timescale 1ns/1ps
module test_cpu_int_level;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] hardLvl = 0;
  logic        bcast15 = 0, masterOff = 0, timerIn = 0;
  logic        busSel = 0, busWr = 0;
  logic [1:0]  busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [15:0] levelOut;

  int nChk = 0, nBad = 0, cyc = 0;
  logic [31:0] softM = 0;
  logic        b15M = 0;

  always #2.5 clk = ~clk;

  cpu_int_level i_cpu_int_level (
    .clk(clk), .rst_n(rst_n), .hardLvl(hardLvl), .bcast15(bcast15), .masterOff(masterOff),
    .timerIn(timerIn), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .levelOut(levelOut)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: act=%0d exp<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  function automatic logic [31:0] expPend();
    return softM | (32'(b15M) << 15) | (32'(timerIn) << 14) | (32'(hardLvl) & 32'h3ffe);
  endfunction

  function automatic logic [15:0] expLvl();
    logic [31:0] p = expPend();
    logic [15:0] v = (hardLvl & 16'hfffe) | 16'(softM >> 16);
    if (!masterOff) v = v | (p[15:0] & 16'hc000);
    return v;
  endfunction

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic checkAll(string tag);
    busAddr = 0; #0.5;
    chk32({tag, " pend"}, busRdata, expPend());
    chk32({tag, " lvl"}, {16'h0, levelOut}, {16'h0, expLvl()});
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busSel = 0; busWr = 0; busAddr = 0;
    if (a == 2) softM = softM | (d & 32'hfffe0000);
    if (a == 1) begin
      softM = softM & ~d;
      if (d[15]) b15M = 0;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setBcast(logic v);
    @(negedge clk);
    if (v && !bcast15) b15M = 1;
    if (!v && bcast15) b15M = 0;
    bcast15 = v;
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R9 reset");
    rst_n = 1;
    settle();
    checkAll("R9 after release");

    for (int k = 0; k < 32; k++) begin
      busWrite(2'd1, 32'hffffffff);
      busWrite(2'd2, 32'd1 << k);
      checkAll($sformatf("R2 set bit %0d", k));
    end

    busWrite(2'd2, 32'hffffffff);
    checkAll("R2 set all ones");
    for (int a = 1; a < 4; a++) begin
      busAddr = 2'(a); #0.5;
      chk32($sformatf("R1 offset %0d reads 0", a), busRdata, 32'h0);
    end
    busWrite(2'd1, 32'haaaaaaaa);
    checkAll("R3 clear alternate");
    chk32("R3 clear alt value", expPend(), 32'h55540000);
    busWrite(2'd1, 32'h0001ffff);
    checkAll("R3 low data bits ignored");
    busWrite(2'd3, 32'hffffffff);
    checkAll("R1 write offset 3 ignored");
    busWrite(2'd0, 32'hffffffff);
    checkAll("R1 write offset 0 ignored");

    repeat (5) @(posedge clk);
    @(negedge clk);
    checkAll("R7 soft bits held");

    for (int m = 0; m < 2; m++) begin
      masterOff = 1'(m);
      for (int k = 0; k < 16; k++) begin
        @(negedge clk); hardLvl = 16'd1 << k;
        settle();
        checkAll($sformatf("R6 R8 hard level %0d off=%0d", k, m));
      end
      hardLvl = 0;
    end
    masterOff = 0;
    busWrite(2'd1, 32'hffffffff);

    @(negedge clk); timerIn = 1; settle();
    checkAll("R4 timer on");
    @(negedge clk); masterOff = 1; settle();
    checkAll("R4 timer blocked");
    @(negedge clk); masterOff = 0; timerIn = 0; settle();
    checkAll("R4 timer off");

    setBcast(1);
    checkAll("R5 bcast rise");
    @(negedge clk); masterOff = 1; settle();
    checkAll("R5 bcast blocked");
    @(negedge clk); masterOff = 0; settle();
    setBcast(0);
    checkAll("R5 bcast fall");
    setBcast(1);
    busWrite(2'd1, 32'h00008000);
    checkAll("R5 clear while high");
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R5 stays clear while high");
    setBcast(0);

    busWrite(2'd1, 32'hffffffff);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 2; busWdata = 32'h00040000;
    @(posedge clk); @(negedge clk);
    busSel = 0; busWr = 0; busAddr = 0; #0.5;
    chk32("R10 pend after first edge", busRdata, 32'h00040000);
    chk32("R10 lvl not yet", {16'h0, levelOut}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk32("R10 lvl after second edge", {16'h0, levelOut}, 32'h4);
    softM = 32'h00040000;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule